// File: doc/BRIEF.md
# TDM Slot Transmitter with Line Release

This block serialises audio words onto a single data line laid out as a time-division-multiplexed frame. Each clock cycle is one bit clock. A one-cycle frame-start pulse begins a frame. The frame is divided into slots of a configurable width. A per-slot mask marks which slots carry data from this transmitter. Words arrive on a valid/ready interface and are taken only when an active slot begins. They are placed in a 32-bit shift register and sent most significant bit first. Any bits that follow the data inside the slot are zero fill.

The block drives two outputs, a data bit and an output-enable, so that several transmitters can share one physical line. A mode input selects what happens outside this transmitter's data. In drive-zero mode the line is held low with the enable asserted. In release mode the enable is dropped, with the timing computed bit by bit:
- In inactive slots.
- In the zero fill of an active slot whose successor is not active, which leaves a guard gap before the next transmitter.
- In the fill at the end of the frame that the slots do not cover.

If no word is offered when an active slot starts, zeros are sent and a sticky underrun flag is raised.

Top module: `tdm_slot_tx`

## Requirements
- R1: After reset `sd`, `sd_oe`, `s_ready` and `underrun` are 0, and `sd_oe` stays 0 until the first `frame_start` pulse is seen, whatever the mode.
- R2: `frame_start` is sampled at a clock edge, and the bit registered at that edge is bit 0 of slot 0. The data size code `cfg_data_size` gives D = 8·(code+1) bits (00=8, 01=16, 10=24, 11=32). The low D bits of the word go out MSB first, one per cycle, with `sd_oe` high.
- R3: The slot size code `cfg_slot_size` selects the slot length: 00 = equal to D, 01 = 16 bits, 10 or 11 = 32 bits. Slot k occupies frame bits k·S to k·S+S−1.
- R4: `s_ready` is high in exactly those cycles whose following bit is bit 0 of an active slot. A slot is active when bit k of `cfg_slot_mask` is 1 and k < `cfg_num_slots`. A word is consumed only when `s_valid` and `s_ready` are both high.
- R5: If `s_valid` is low when an active slot starts, that slot's data bits are sent as zeros with `sd_oe` high, and `underrun` becomes 1 and stays 1 until reset.
- R6: With `cfg_tristate` = 0, every bit after the first frame start that is not a data bit is driven as 0 with `sd_oe` = 1. This covers inactive slots, slot zero fill and end-of-frame fill.
- R7: With `cfg_tristate` = 1, `sd_oe` is 0 for every bit of an inactive slot.
- R8: With `cfg_tristate` = 1, during the zero fill of active slot k, `sd_oe` is 1 only if slot k+1 exists (k+1 < `cfg_num_slots`) and is active. Otherwise `sd_oe` is 0.
- R9: Frame bits at or beyond `cfg_frame_len`, and bits beyond the last slot, are end-of-frame fill. The fill is 0 with `sd_oe` = 1 in drive-zero mode and `sd_oe` = 0 in release mode. The fill continues until the next `frame_start`.
- R10: Whenever `sd_oe` is 0, `sd` is 0.
- R11: A `frame_start` pulse in the middle of a frame restarts the frame at once: the next bit is bit 0 of slot 0 under the configuration present in the pulse cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that begins a frame |
| cfg_frame_len | input | FLEN_W (9) | Frame length in bit clocks |
| cfg_num_slots | input | $clog2(MAX_SLOTS+1) (5) | Number of slots per frame |
| cfg_slot_size | input | 2 | Slot length code |
| cfg_data_size | input | 2 | Data length code |
| cfg_slot_mask | input | MAX_SLOTS (16) | Per-slot active bit, bit k for slot k |
| cfg_tristate | input | 1 | 1 = release line outside own data, 0 = drive zero |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word accepted at this edge |
| s_data | input | 32 | Input word, data in the low D bits |
| sd | output | 1 | Serial data bit |
| sd_oe | output | 1 | Output-enable for the shared line |
| underrun | output | 1 | Sticky: an active slot started with no word |

## Verification
The properties assume that the configuration inputs are held steady within a frame and change only in the cycle that carries `frame_start`. The drive-zero property compares the enable against the mode of the previous cycle on that basis. The bench changes the configuration only in the pulse cycle, and it keeps the data size no larger than the slot size. It drives `s_valid` from a word queue that stays non-empty, except in a frame that is starved on purpose. Under these conditions the underrun flag can rise only after a slot start with no word, and the bench's reference model needs no knowledge of out-of-range settings.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        BK_OFF,
        BK_DATA,
        BK_SLOT_PAD,
        BK_IDLE_SLOT,
        BK_FRAME_PAD
    } bit_kind_e;

    typedef struct packed {
        bit_kind_e kind;
        logic      oe;
        logic      load;
    } bit_ctl_t;

    function automatic logic [5:0] data_bits(input logic [1:0] ds);
        return (6'(ds) + 6'd1) << 3;
    endfunction

    function automatic logic [5:0] slot_bits(input logic [1:0] ss, input logic [1:0] ds);
        case (ss)
            2'b00:   return data_bits(ds);
            2'b01:   return 6'd16;
            default: return 6'd32;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] msb_align(input logic [WORD_W-1:0] w,
                                                    input logic [1:0] ds);
        return w << (6'd32 - data_bits(ds));
    endfunction

endpackage

// File: rtl/tdm_pos_counter.sv
module tdm_pos_counter #(
    parameter int FLEN_W = 9,
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [FLEN_W-1:0] cfg_frame_len,
    input  logic [SLOT_W-1:0] cfg_num_slots,
    input  logic [5:0]        slot_len,
    output logic              nxt_started,
    output logic [FLEN_W-1:0] nxt_fpos,
    output logic [SLOT_W-1:0] nxt_slot,
    output logic [5:0]        nxt_bit
);
    localparam logic [FLEN_W-1:0] FONE = 1;
    localparam logic [SLOT_W-1:0] SONE = 1;

    logic              started_q;
    logic [FLEN_W-1:0] fpos_q;
    logic [SLOT_W-1:0] slot_q;
    logic [5:0]        bit_q;
    logic              wrap;

    assign wrap = (bit_q == slot_len - 6'd1);

    always_comb begin
        nxt_started = started_q;
        nxt_fpos    = fpos_q;
        nxt_slot    = slot_q;
        nxt_bit     = bit_q;
        if (frame_start) begin
            nxt_started = 1'b1;
            nxt_fpos    = '0;
            nxt_slot    = '0;
            nxt_bit     = '0;
        end else if (started_q) begin
            if (fpos_q < cfg_frame_len)
                nxt_fpos = fpos_q + FONE;
            nxt_bit = wrap ? 6'd0 : bit_q + 6'd1;
            if (wrap && (slot_q < cfg_num_slots))
                nxt_slot = slot_q + SONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q <= 1'b0;
            fpos_q    <= '0;
            slot_q    <= '0;
            bit_q     <= '0;
        end else begin
            started_q <= nxt_started;
            fpos_q    <= nxt_fpos;
            slot_q    <= nxt_slot;
            bit_q     <= nxt_bit;
        end
    end

endmodule

// File: rtl/tdm_bit_class.sv
module tdm_bit_class
    import tdm_tx_pkg::*;
#(
    parameter int MAX_SLOTS = 16,
    parameter int FLEN_W    = 9,
    parameter int SLOT_W    = 5
) (
    input  logic                 started,
    input  logic [FLEN_W-1:0]    fpos,
    input  logic [SLOT_W-1:0]    slot,
    input  logic [5:0]           bit_idx,
    input  logic [FLEN_W-1:0]    cfg_frame_len,
    input  logic [SLOT_W-1:0]    cfg_num_slots,
    input  logic [MAX_SLOTS-1:0] cfg_slot_mask,
    input  logic                 cfg_tristate,
    input  logic [5:0]           data_len,
    output bit_ctl_t             ctl
);
    localparam int IDX_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;
    localparam logic [SLOT_W-1:0] SLOT_LIM = SLOT_W'(MAX_SLOTS);
    localparam logic [SLOT_W-1:0] SONE     = 1;

    logic [MAX_SLOTS-1:0] slot_live;
    logic [SLOT_W-1:0]    slot_p1;
    logic                 in_frame;
    logic                 cur_on;
    logic                 next_on;

    for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_live
        assign slot_live[i] = cfg_slot_mask[i] && (i < int'(cfg_num_slots));
    end

    assign slot_p1  = slot + SONE;
    assign in_frame = (fpos < cfg_frame_len) && (slot < cfg_num_slots);
    assign cur_on   = in_frame && (slot < SLOT_LIM) && slot_live[slot[IDX_W-1:0]];
    assign next_on  = (slot_p1 < SLOT_LIM) && slot_live[slot_p1[IDX_W-1:0]];

    always_comb begin
        ctl.kind = BK_OFF;
        ctl.oe   = 1'b0;
        ctl.load = 1'b0;
        if (!started) begin
            ctl.kind = BK_OFF;
        end else if (!in_frame) begin
            ctl.kind = BK_FRAME_PAD;
            ctl.oe   = !cfg_tristate;
        end else if (!cur_on) begin
            ctl.kind = BK_IDLE_SLOT;
            ctl.oe   = !cfg_tristate;
        end else if (bit_idx < data_len) begin
            ctl.kind = BK_DATA;
            ctl.oe   = 1'b1;
            ctl.load = (bit_idx == 6'd0);
        end else begin
            ctl.kind = BK_SLOT_PAD;
            ctl.oe   = cfg_tristate ? next_on : 1'b1;
        end
    end

endmodule

// File: rtl/tdm_shifter.sv
module tdm_shifter
    import tdm_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic              s_valid,
    input  logic [WORD_W-1:0] s_data,
    input  logic [1:0]        cfg_data_size,
    output logic              bit_out,
    output logic              underrun
);
    logic [WORD_W-1:0] sreg_q;
    logic [WORD_W-1:0] aligned;

    assign aligned = s_valid ? msb_align(s_data, cfg_data_size) : '0;
    assign bit_out = load ? aligned[WORD_W-1] : sreg_q[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q   <= '0;
            underrun <= 1'b0;
        end else if (load) begin
            sreg_q   <= aligned << 1;
            underrun <= underrun | !s_valid;
        end else if (shift) begin
            sreg_q   <= sreg_q << 1;
        end
    end

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
    import tdm_tx_pkg::*;
#(
    parameter int MAX_SLOTS = 16,
    parameter int FLEN_W    = 9,
    localparam int SLOT_W   = $clog2(MAX_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic [FLEN_W-1:0]    cfg_frame_len,
    input  logic [SLOT_W-1:0]    cfg_num_slots,
    input  logic [1:0]           cfg_slot_size,
    input  logic [1:0]           cfg_data_size,
    input  logic [MAX_SLOTS-1:0] cfg_slot_mask,
    input  logic                 cfg_tristate,
    input  logic                 s_valid,
    output logic                 s_ready,
    input  logic [WORD_W-1:0]    s_data,
    output logic                 sd,
    output logic                 sd_oe,
    output logic                 underrun
);
    logic              nxt_started;
    logic [FLEN_W-1:0] nxt_fpos;
    logic [SLOT_W-1:0] nxt_slot;
    logic [5:0]        nxt_bit;
    logic [5:0]        slot_len;
    logic [5:0]        data_len;
    bit_ctl_t          ctl;
    logic              bit_out;

    assign slot_len = slot_bits(cfg_slot_size, cfg_data_size);
    assign data_len = data_bits(cfg_data_size);

    tdm_pos_counter #(.FLEN_W(FLEN_W), .SLOT_W(SLOT_W)) u_pos (
        .clk           (clk),
        .rst           (rst),
        .frame_start   (frame_start),
        .cfg_frame_len (cfg_frame_len),
        .cfg_num_slots (cfg_num_slots),
        .slot_len      (slot_len),
        .nxt_started   (nxt_started),
        .nxt_fpos      (nxt_fpos),
        .nxt_slot      (nxt_slot),
        .nxt_bit       (nxt_bit)
    );

    tdm_bit_class #(.MAX_SLOTS(MAX_SLOTS), .FLEN_W(FLEN_W), .SLOT_W(SLOT_W)) u_cls (
        .started       (nxt_started),
        .fpos          (nxt_fpos),
        .slot          (nxt_slot),
        .bit_idx       (nxt_bit),
        .cfg_frame_len (cfg_frame_len),
        .cfg_num_slots (cfg_num_slots),
        .cfg_slot_mask (cfg_slot_mask),
        .cfg_tristate  (cfg_tristate),
        .data_len      (data_len),
        .ctl           (ctl)
    );

    tdm_shifter u_shf (
        .clk           (clk),
        .rst           (rst),
        .load          (ctl.load),
        .shift         (ctl.kind == BK_DATA),
        .s_valid       (s_valid),
        .s_data        (s_data),
        .cfg_data_size (cfg_data_size),
        .bit_out       (bit_out),
        .underrun      (underrun)
    );

    assign s_ready = ctl.load;

    always_ff @(posedge clk) begin
        if (rst) begin
            sd    <= 1'b0;
            sd_oe <= 1'b0;
        end else begin
            sd_oe <= ctl.oe;
            sd    <= ctl.oe && (ctl.kind == BK_DATA) && bit_out;
        end
    end

endmodule

// File: rtl/tdm_slot_tx_chk.sv
module tdm_slot_tx_chk #(
    parameter int MAX_SLOTS = 16,
    parameter int FLEN_W    = 9,
    parameter int SLOT_W    = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 frame_start,
    input logic                 cfg_tristate,
    input logic                 s_valid,
    input logic                 s_ready,
    input logic                 sd,
    input logic                 sd_oe,
    input logic                 underrun
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= 1'b0;
        else if (frame_start)
            seen_q <= 1'b1;
    end

    // R10
    released_low_chk: assert property (@(posedge clk) disable iff (rst)
        !sd_oe |-> !sd);

    // R5
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    // R5
    underrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> ($past(s_ready) && !$past(s_valid)));

    // R4
    ready_window_chk: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (seen_q || frame_start));

    // R1
    quiet_before_start_chk: assert property (@(posedge clk) disable iff (rst)
        !seen_q |-> (!sd_oe && !underrun));

    // R6
    zero_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && !$past(cfg_tristate)) |-> sd_oe);

endmodule

bind tdm_slot_tx tdm_slot_tx_chk #(
    .MAX_SLOTS (MAX_SLOTS),
    .FLEN_W    (FLEN_W),
    .SLOT_W    (SLOT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .cfg_tristate (cfg_tristate),
    .s_valid      (s_valid),
    .s_ready      (s_ready),
    .sd           (sd),
    .sd_oe        (sd_oe),
    .underrun     (underrun)
);

// File: tb/tb_tdm_slot_tx.sv
module tb_tdm_slot_tx;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    logic [8:0]  cfg_frame_len = '0;
    logic [4:0]  cfg_num_slots = '0;
    logic [1:0]  cfg_slot_size = '0;
    logic [1:0]  cfg_data_size = '0;
    logic [15:0] cfg_slot_mask = '0;
    logic        cfg_tristate = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [31:0] s_data = '0;
    logic        sd;
    logic        sd_oe;
    logic        underrun;

    int checks = 0;
    int failures = 0;

    typedef struct {
        bit    oe;
        bit    sd;
        string req;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] wq[$];
    logic [31:0] mq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_slot_tx dut (
        .clk           (clk),
        .rst           (rst),
        .frame_start   (frame_start),
        .cfg_frame_len (cfg_frame_len),
        .cfg_num_slots (cfg_num_slots),
        .cfg_slot_size (cfg_slot_size),
        .cfg_data_size (cfg_data_size),
        .cfg_slot_mask (cfg_slot_mask),
        .cfg_tristate  (cfg_tristate),
        .s_valid       (s_valid),
        .s_ready       (s_ready),
        .s_data        (s_data),
        .sd            (sd),
        .sd_oe         (sd_oe),
        .underrun      (underrun)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected bit per clock, sampled after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check_eq(e.req, "sd_oe", {31'd0, sd_oe}, {31'd0, e.oe});
                check_eq(e.req, "sd", {31'd0, sd}, {31'd0, e.sd});
                if (!sd_oe)
                    check_eq("R10", "sd while released", {31'd0, sd}, 32'd0);
            end
        end
    end

    task automatic push_word(input logic [31:0] w);
        wq.push_back(w);
        mq.push_back(w);
    endtask

    function automatic int dsize(input logic [1:0] ds);
        return 8 * (int'(ds) + 1);
    endfunction

    function automatic int ssize(input logic [1:0] ss, input logic [1:0] ds);
        if (ss == 2'b00) return dsize(ds);
        if (ss == 2'b01) return 16;
        return 32;
    endfunction

    // Reference model: expected bits of one frame run, per the requirements.
    task automatic build(input int cycles, input int flen, input int ns,
                         input logic [1:0] ss, input logic [1:0] ds,
                         input logic [15:0] mask, input bit tri_m,
                         input bit starve, input string tag, output int loads);
        int          S;
        int          D;
        logic [31:0] cur;
        S = ssize(ss, ds);
        D = dsize(ds);
        cur = '0;
        loads = 0;
        for (int p = 0; p < cycles; p++) begin
            exp_t e;
            int   s;
            int   b;
            s = p / S;
            b = p % S;
            e.sd = 1'b0;
            if (p >= flen || s >= ns) begin
                e.oe  = !tri_m;
                e.req = tri_m ? "R9" : "R6";
            end else if (!mask[s]) begin
                e.oe  = !tri_m;
                e.req = tri_m ? "R7" : "R6";
            end else begin
                if (b == 0) begin
                    loads++;
                    if (starve) cur = '0;
                    else        cur = mq.pop_front();
                end
                if (b < D) begin
                    e.oe  = 1'b1;
                    e.sd  = cur[D-1-b];
                    e.req = "R2";
                end else begin
                    e.oe  = tri_m ? ((s + 1 < ns) && mask[s+1]) : 1'b1;
                    e.req = tri_m ? "R8" : "R6";
                end
            end
            if (tag != "") e.req = tag;
            exp_q.push_back(e);
        end
    endtask

    // Driver: configures in the pulse cycle, feeds words, counts ready cycles.
    task automatic run_frame(input int cycles, input int flen, input int ns,
                             input logic [1:0] ss, input logic [1:0] ds,
                             input logic [15:0] mask, input bit tri_m,
                             input bit starve, input string tag);
        int loads;
        int rdy;
        rdy = 0;
        loads = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (c == 0) begin
                frame_start   = 1'b1;
                cfg_frame_len = 9'(flen);
                cfg_num_slots = 5'(ns);
                cfg_slot_size = ss;
                cfg_data_size = ds;
                cfg_slot_mask = mask;
                cfg_tristate  = tri_m;
                build(cycles, flen, ns, ss, ds, mask, tri_m, starve, tag, loads);
            end else begin
                frame_start = 1'b0;
            end
            s_valid = !starve && (wq.size() > 0);
            s_data  = s_valid ? wq[0] : 32'd0;
            #1;
            if (s_ready) rdy++;
            if (s_valid && s_ready) void'(wq.pop_front());
        end
        check_eq("R4", "ready cycles per frame", 32'(rdy), 32'(loads));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 24; i++)
            push_word(32'hA5C3_0F96 ^ (32'(i) * 32'h9E37_79B9));

        repeat (3) @(negedge clk);
        #1;
        check_eq("R1", "sd in reset", {31'd0, sd}, 32'd0);
        check_eq("R1", "sd_oe in reset", {31'd0, sd_oe}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        check_eq("R1", "sd_oe before first frame", {31'd0, sd_oe}, 32'd0);
        check_eq("R1", "s_ready before first frame", {31'd0, s_ready}, 32'd0);
        check_eq("R1", "underrun after reset", {31'd0, underrun}, 32'd0);

        // drive-zero, 16-bit data in 16-bit slots, slot 2 idle, frame fill
        run_frame(76, 72, 4, 2'b00, 2'b01, 16'b1011, 1'b0, 1'b0, "");
        // release, 24-bit data in 32-bit slots, guard gap before idle slot 3
        run_frame(170, 160, 4, 2'b10, 2'b10, 16'b0110, 1'b1, 1'b0, "");
        // release, 8-bit data in 16-bit slots, last slot releases in its fill
        run_frame(48, 48, 3, 2'b01, 2'b00, 16'b0111, 1'b1, 1'b0, "");
        // release, 24-bit slots equal to data size
        run_frame(60, 60, 2, 2'b00, 2'b10, 16'b0011, 1'b1, 1'b0, "R3");
        // drive-zero, full 32-bit words
        run_frame(64, 64, 2, 2'b10, 2'b11, 16'b0011, 1'b0, 1'b0, "");
        #1;
        check_eq("R5", "no underrun while fed", {31'd0, underrun}, 32'd0);
        // starved frame: zeros with enable high, flag raised
        run_frame(40, 40, 1, 2'b10, 2'b11, 16'b0001, 1'b1, 1'b1, "R5");
        #1;
        check_eq("R5", "underrun after starved slot", {31'd0, underrun}, 32'd1);
        // frame cut short by a new pulse, then a frame shorter than its slots
        run_frame(40, 128, 4, 2'b01, 2'b01, 16'h000F, 1'b1, 1'b0, "");
        run_frame(52, 40, 4, 2'b01, 2'b01, 16'h000F, 1'b0, 1'b0, "R11");
        @(negedge clk);
        frame_start = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check_eq("R5", "underrun stays set", {31'd0, underrun}, 32'd1);
        check_eq("R9", "expected queue drained", 32'(exp_q.size()), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule